// File: doc/BRIEF.md
# Pipelined Phase Accumulator for Digital Frequency Synthesis

This block keeps the running phase of a numerically controlled oscillator. On every enabled clock it adds a frequency tuning word to the phase, so the phase advances at a rate proportional to that word. The full-width addition is split into byte-wide slices. Each slice sits in its own pipeline stage and uses a Brent-Kung parallel-prefix adder. The carry out of each slice is registered and reaches the next slice one enabled cycle later. This keeps the critical path at one byte-wide prefix adder, whatever the total width.

Delay registers skew the tuning-word bytes on the way in, so that byte k of a word meets the carry from byte k-1 in the right stage. Delay registers on the way out deskew the result bytes, so every phase sample on the output is one coherent accumulator value. A valid flag marks the point from which the output holds real sums. The phase is meant to feed a phase-to-amplitude stage further down the chain.

Top module: `phase_accum_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, every internal register is cleared, and after that edge `phase` is 0 and `phase_valid` is 0, whatever `en` and `tune_word` hold.
- R2: `phase_valid` rises after the 4th rising edge with `en` high since reset (NUM_SLICES such edges) and stays high until the next reset.
- R3: While `phase_valid` is low, `phase` reads 0.
- R4: Number the enabled edges since reset 1, 2, 3, and so on. After enabled edge j, `phase` equals the sum, modulo 2^32, of the tuning words sampled at enabled edges 1 through j-3. A word therefore appears NUM_SLICES-1 enabled edges after it is sampled.
- R5: Carries cross every byte boundary correctly. This includes a carry that chains through all four bytes, as happens when 0x00FFFFFF or 0xFFFFFFFF is added to a phase whose low byte is nonzero.
- R6: The phase wraps modulo 2^32, and the carry out of the top slice is discarded.
- R7: A rising edge with `en` low changes no state. `phase` and `phase_valid` keep their values, and once `en` returns the sums continue with no carry lost or counted twice.
- R8: When the tuning word changes from one enabled cycle to the next, each output sample reflects whole words only. Consecutive valid samples differ by exactly one sampled word, never by a word made of bytes from two different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the pipeline and accumulate on this edge |
| tune_word | input | 32 (ACC_W) | Frequency tuning word added each enabled cycle |
| phase | output | 32 (ACC_W) | Byte-aligned accumulated phase |
| phase_valid | output | 1 | High once the pipeline holds real sums |

## Verification
Two events can fall in the same cycle: a carry that is still moving between slice registers, and a stall (`en` low) or a change of tuning word. The bench adds 0x00FFFFFF and all-ones words so that carries chain through every stage. While those carries are in flight it drops `en` on alternate cycles, and separately it swaps between two words with complementary byte patterns on every cycle. A behavioural full-width accumulator, advanced only on enabled edges and delayed by three enabled edges, judges every output sample.

// File: rtl/phase_accum_pipe.sv
module phase_accum_pipe #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic [SLICE_W*NUM_SLICES-1:0] tune_word,
  output logic [SLICE_W*NUM_SLICES-1:0] phase,
  output logic                          phase_valid
);
  localparam int ACC_W = SLICE_W * NUM_SLICES;
  localparam int LOGW  = $clog2(SLICE_W);

  // Brent-Kung prefix adder for one slice; returns {carry_out, sum}
  function automatic logic [SLICE_W:0] bk_add(input logic [SLICE_W-1:0] a,
                                              input logic [SLICE_W-1:0] b,
                                              input logic               cin);
    logic [SLICE_W-1:0] g, p, gg, pp;
    logic [SLICE_W:0]   c;
    g  = a & b;
    p  = a ^ b;
    gg = g;
    pp = p;
    gg[0] = g[0] | (p[0] & cin);
    for (int l = 0; l < LOGW; l++)
      for (int i = 0; i < SLICE_W; i++)
        if (((i + 1) % (1 << (l + 1))) == 0) begin
          gg[i] = gg[i] | (pp[i] & gg[(i + SLICE_W - (1 << l)) % SLICE_W]);
          pp[i] = pp[i] & pp[(i + SLICE_W - (1 << l)) % SLICE_W];
        end
    for (int l = LOGW - 2; l >= 0; l--)
      for (int i = 0; i < SLICE_W; i++)
        if ((((i + 1) % (1 << (l + 1))) == (1 << l)) && (i >= (1 << (l + 1))))
          gg[i] = gg[i] | (pp[i] & gg[(i + SLICE_W - (1 << l)) % SLICE_W]);
    c = {gg, cin};
    return {c[SLICE_W], p ^ c[SLICE_W-1:0]};
  endfunction

  logic [NUM_SLICES-1:0][SLICE_W-1:0] acc_q;
  logic [NUM_SLICES-1:0][SLICE_W-1:0] byte_in;
  logic [NUM_SLICES-1:0][SLICE_W-1:0] sum_c;
  logic [NUM_SLICES-1:0]              cout_c;
  logic [NUM_SLICES-2:0]              carry_q;
  logic [NUM_SLICES-1:0]              cin_v;
  logic [NUM_SLICES-1:0]              vld_sr;

  assign cin_v = {carry_q, 1'b0};

  always_comb begin
    for (int k = 0; k < NUM_SLICES; k++)
      {cout_c[k], sum_c[k]} = bk_add(acc_q[k], byte_in[k], cin_v[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      carry_q <= '0;
      vld_sr  <= '0;
    end else if (en) begin
      acc_q  <= sum_c;
      for (int k = 0; k < NUM_SLICES - 1; k++)
        carry_q[k] <= cout_c[k];
      vld_sr <= {vld_sr[NUM_SLICES-2:0], 1'b1};
    end
  end

  assign phase_valid = vld_sr[NUM_SLICES-1];

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    localparam int DESK = NUM_SLICES - 1 - k;

    if (k == 0) begin : g_noskew
      assign byte_in[k] = tune_word[k*SLICE_W +: SLICE_W];
    end else begin : g_skew
      logic [SLICE_W-1:0] skew_q [k];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int d = 0; d < k; d++) skew_q[d] <= '0;
        end else if (en) begin
          skew_q[0] <= tune_word[k*SLICE_W +: SLICE_W];
          for (int d = 1; d < k; d++) skew_q[d] <= skew_q[d-1];
        end
      end
      assign byte_in[k] = skew_q[k-1];
    end

    if (DESK == 0) begin : g_nodesk
      assign phase[k*SLICE_W +: SLICE_W] = acc_q[k];
    end else begin : g_desk
      logic [SLICE_W-1:0] desk_q [DESK];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int d = 0; d < DESK; d++) desk_q[d] <= '0;
        end else if (en) begin
          desk_q[0] <= acc_q[k];
          for (int d = 1; d < DESK; d++) desk_q[d] <= desk_q[d-1];
        end
      end
      assign phase[k*SLICE_W +: SLICE_W] = desk_q[DESK-1];
    end
  end

  initial begin
    if (ACC_W != SLICE_W * NUM_SLICES || NUM_SLICES < 2 || (1 << LOGW) != SLICE_W)
      $error("phase_accum_pipe: unsupported parameters");
  end
endmodule

// File: rtl/phase_accum_pipe_chk.sv
module phase_accum_pipe_chk #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          en,
  input logic [SLICE_W*NUM_SLICES-1:0] tune_word,
  input logic [SLICE_W*NUM_SLICES-1:0] phase,
  input logic                          phase_valid
);
  localparam int ACC_W = SLICE_W * NUM_SLICES;
  localparam int CW    = $clog2(NUM_SLICES + 1);

  logic [CW-1:0]                    en_cnt;
  logic [NUM_SLICES-1:0][ACC_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_cnt <= '0;
      hist   <= '0;
    end else if (en) begin
      if (en_cnt != CW'(NUM_SLICES)) en_cnt <= en_cnt + 1'b1;
      hist <= {hist[NUM_SLICES-2:0], tune_word};
    end
  end

  assert_valid_timing_R2: assert property (@(posedge clk) disable iff (rst)
    phase_valid == (en_cnt == CW'(NUM_SLICES)));

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    phase_valid |=> phase_valid);

  assert_zero_before_valid_R3: assert property (@(posedge clk) disable iff (rst)
    !phase_valid |-> phase == '0);

  assert_step_one_word_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(phase_valid) && phase_valid)
      |-> phase == $past(phase) + hist[NUM_SLICES-1]);

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(phase) && $stable(phase_valid)));
endmodule

bind phase_accum_pipe phase_accum_pipe_chk #(
  .SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .tune_word(tune_word),
  .phase(phase), .phase_valid(phase_valid)
);

// File: tb/phase_accum_pipe_tb.sv
`timescale 1ns/1ps
module phase_accum_pipe_tb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] tune_word = '0;
  logic [31:0] phase;
  logic        phase_valid;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] ref_acc;
  logic [31:0] ref_d [LAT];
  logic [31:0] exp_phase;
  int          en_cnt;

  always #2.5 clk = ~clk;

  phase_accum_pipe u_dut (
    .clk(clk), .rst(rst), .en(en), .tune_word(tune_word),
    .phase(phase), .phase_valid(phase_valid)
  );

  task automatic step(input logic r, input logic e, input logic [31:0] w, input string tag);
    logic expv;
    rst = r; en = e; tune_word = w;
    @(posedge clk);
    if (r) begin
      ref_acc = '0; exp_phase = '0; en_cnt = 0;
      for (int i = 0; i < LAT; i++) ref_d[i] = '0;
    end else if (e) begin
      exp_phase = ref_d[LAT-1];
      for (int i = LAT - 1; i > 0; i--) ref_d[i] = ref_d[i-1];
      ref_acc = ref_acc + w;
      ref_d[0] = ref_acc;
      if (en_cnt < LAT + 1) en_cnt++;
    end
    @(negedge clk);
    expv = (en_cnt >= LAT + 1);
    n_tests++;
    if (phase !== exp_phase || phase_valid !== expv) begin
      n_fail++;
      $display("FAIL %s: phase=%h valid=%b expected phase=%h valid=%b",
               tag, phase, phase_valid, exp_phase, expv);
    end
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < LAT; i++) step(1'b0, 1'b1, 32'h0, tag);
  endtask

  // R1: reset clears output regardless of en and word
  task automatic t_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, $urandom, "R1");
  endtask

  // R2 and R3: valid after the 4th enabled edge, zero output before
  task automatic t_fill();
    t_reset();
    step(1'b0, 1'b0, 32'h1234_5678, "R3");
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 32'h0101_0101 * (i + 1), "R2");
  endtask

  // R4: random words, steady accumulation
  task automatic t_random();
    t_reset();
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, $urandom, "R4");
    flush("R4");
  endtask

  // R5: carries chained through every byte boundary
  task automatic t_carry();
    t_reset();
    step(1'b0, 1'b1, 32'h0000_0001, "R5");
    step(1'b0, 1'b1, 32'h00FF_FFFF, "R5");
    step(1'b0, 1'b1, 32'h0000_00FF, "R5");
    step(1'b0, 1'b1, 32'h0000_0001, "R5");
    step(1'b0, 1'b1, 32'h00FF_FFFF, "R5");
    step(1'b0, 1'b1, 32'hFFFF_FFFF, "R5");
    step(1'b0, 1'b1, 32'h00FF_FFFF, "R5");
    flush("R5");
  endtask

  // R6: wrap modulo 2^32
  task automatic t_wrap();
    t_reset();
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 32'hFFFF_FFFF, "R6");
    step(1'b0, 1'b1, 32'h8000_0000, "R6");
    step(1'b0, 1'b1, 32'h8000_0006, "R6");
    flush("R6");
  endtask

  // R7: stalls interleaved with carries in flight
  task automatic t_stall();
    t_reset();
    for (int i = 0; i < 24; i++)
      step(1'b0, (i % 2) == 0, (i % 3 == 0) ? 32'h00FF_FFFF : 32'hFFFF_FFFF, "R7");
    for (int i = 0; i < 20; i++)
      step(1'b0, ($urandom % 3) != 0, $urandom, "R7");
    flush("R7");
  endtask

  // R8: word changes every cycle, byte patterns complementary
  task automatic t_switch();
    t_reset();
    for (int i = 0; i < 16; i++)
      step(1'b0, 1'b1, (i % 2 == 0) ? 32'h0101_0101 : 32'hFEFE_FEFF, "R8");
    flush("R8");
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    ref_acc = '0; exp_phase = '0; en_cnt = 0;
    for (int i = 0; i < LAT; i++) ref_d[i] = '0;
    t_reset();
    t_fill();
    t_random();
    t_carry();
    t_wrap();
    t_stall();
    t_switch();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule